// File: doc/BRIEF.md
# Page-wide Hamming ECC engine

This engine watches the word stream moving between a NAND flash device and its controller and folds a whole page into one Hamming-style check value. Each word may be 8 or 16 bits wide. For every '1' data bit, the engine XORs the bit's position {word address, bit offset} into a 16-bit parity accumulator. The complemented parity word carries the XOR of the inverted positions. It therefore equals the parity word XORed with the overall bit parity spread across all 16 bits.

On a write pass, software reads both 16-bit words once the page data has streamed past and stores them as four spare-area bytes. On a read pass, the four stored bytes follow the last data word directly. The engine compares them with the recomputed code and latches a verdict:
- clean,
- one flipped data bit, with its location,
- a flipped bit inside the stored code,
- or several errors.

Software fixes the data bit itself.

The page length, bus width and pass type are captured when a page is started. The engine ignores every input word outside an active pass.

Top module: `page_ecc_engine`

## Requirements
- R1: After reset, and in the cycle after `page_start`, `parity_word`, `nparity_word`, `err_flag`, `mult_flag`, `code_flag` and `done` are all 0.
- R2: After a write pass, `parity_word` equals the XOR of {word_address[11:0], bit_offset[3:0]} over every '1' data bit of the page. `nparity_word` equals the XOR of the bitwise inverse of those same positions.
- R3: `size_sel` captured at `page_start` fixes the data area: 0, 1, 2 and 3 select 512, 1024, 2048 and 4096 data bytes. These are pages of 528, 1056, 2112 and 4224 bytes including the spare area.
- R4: With `wide_bus`=1, a data word is `din[15:0]`, bit offsets run 0 to 15, and word addresses count 16-bit words. With `wide_bus`=0, only `din[7:0]` is used and `din[15:8]` has no effect.
- R5: On a read pass, the stored code follows the data. On an 8-bit bus it arrives as four beats in this order: parity low byte, parity high byte, complement low byte, complement high byte. On a 16-bit bus it arrives as two beats: parity word, then complement word.
- R6: A read pass whose data and code match leaves all three flags at 0 and both parity outputs at 0.
- R7: A single flipped data bit sets `err_flag`=1 with `mult_flag`=0 and `code_flag`=0. `parity_word[3:0]` then holds its bit offset, `parity_word[15:4]` holds its word address, and `nparity_word` holds the inverse of `parity_word`.
- R8: A single flipped bit inside the stored code sets `err_flag`=1 and `code_flag`=1, with `mult_flag`=0.
- R9: Two flipped data bits set `err_flag`=1 and `mult_flag`=1, with `code_flag`=0.
- R10: An erased page, where every data and code byte is 0xFF, produces `mult_flag`=1 and `err_flag`=1, with `parity_word` and `nparity_word` both 0xFFFF.
- R11: `done` is a one-cycle pulse in the cycle after the clock edge that absorbs the final beat. That final beat is the last data word of a write pass or the last code beat of a read pass. Outputs then hold, and later `din_valid` beats are ignored, until the next `page_start`.
- R12: When `page_start` and `din_valid` are high together, `page_start` wins and the word is dropped. Before the first `page_start` after reset, input words have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_start | input | 1 | Clears the engine and captures the configuration for a new page |
| size_sel | input | 2 | Page length selection, captured at page_start |
| wide_bus | input | 1 | 1 = 16-bit words, 0 = 8-bit words, captured at page_start |
| read_check | input | 1 | 1 = read pass with code compare, 0 = write pass, captured at page_start |
| din_valid | input | 1 | Qualifies din for one beat |
| din | input | 16 | Data word or code beat |
| parity_word | output | 16 | Running or final parity; the syndrome after a read pass |
| nparity_word | output | 16 | Complemented parity; the complemented syndrome after a read pass |
| err_flag | output | 1 | An error was detected |
| mult_flag | output | 1 | Uncorrectable multi-bit error |
| code_flag | output | 1 | The single error lies in the stored code |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can land in the same cycle: the start of a new page and the absorption of a beat. The bench provokes the worst case by streaming a page up to its last data word and presenting that word together with `page_start`. It then checks that no `done` pulse follows and that the outputs are cleared. It also checks that a complete page sent afterwards counts its words from address zero and yields the reference code. The bench also presents a beat in the cycle after the final one, while the engine is holding, and confirms that neither the verdict nor the syndrome moves.

// File: rtl/ecc_pkg.sv
// Shared types for the page ECC engine.
// Assumes: nothing beyond IEEE 1800-2017.
package ecc_pkg;

    // Pass phase of the engine.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // waiting for the first page_start
        PH_DATA = 2'd1,   // absorbing page data words
        PH_CODE = 2'd2,   // absorbing stored code beats (read pass)
        PH_HOLD = 2'd3    // pass complete, outputs frozen
    } phase_t;

    // Verdict of a read check.
    typedef struct packed {
        logic err;        // any mismatch
        logic mult;       // not correctable
        logic code_err;   // single error inside the stored code
    } verdict_t;

endpackage

// File: rtl/ecc_word_fold.sv
// Folds one data word into a position XOR and a bit parity.
// Every '1' bit b of the word at address A contributes {A, b}.
// Assumes DATA_W == 2**BIT_W; the narrow mode uses the low byte only.
module ecc_word_fold #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12,
    parameter int BIT_W  = 4
) (
    input  logic [ADDR_W-1:0]       word_addr,
    input  logic [DATA_W-1:0]       din,
    input  logic                    wide,
    output logic [ADDR_W+BIT_W-1:0] pos_xor,
    output logic                    bit_par
);
    localparam int POS_W    = ADDR_W + BIT_W;
    localparam int NARROW_W = 8;

    logic [DATA_W-1:0] live;
    logic [POS_W-1:0]  term [DATA_W];

    // Mask the upper lanes when the bus is 8 bits wide.
    always_comb begin
        live = din;
        if (!wide) begin
            live[DATA_W-1:NARROW_W] = '0;
        end
    end

    // One position term per bit lane.
    for (genvar b = 0; b < DATA_W; b++) begin : g_lane
        assign term[b] = live[b] ? {word_addr, BIT_W'(b)} : '0;
    end

    // XOR-reduce the lane terms.
    always_comb begin
        pos_xor = '0;
        for (int i = 0; i < DATA_W; i++) begin
            pos_xor = pos_xor ^ term[i];
        end
    end

    assign bit_par = ^live;

    // Guard the lane/offset relation at elaboration.
    initial begin
        assert (DATA_W == (1 << BIT_W))
            else $error("DATA_W must equal 2**BIT_W");
    end

endmodule

// File: rtl/ecc_seq_ctrl.sv
// Sequencer: tracks the phase, word address and code beat of a pass.
// Captures the configuration at page_start, which always wins over din_valid.
// Raises done for one cycle after the final beat is absorbed.
// Assumes configuration inputs are meaningful only while page_start is high.
module ecc_seq_ctrl import ecc_pkg::*; #(
    parameter int ADDR_W     = 12,
    parameter int SEL_W      = 2,
    parameter int BASE_BYTES = 512,
    parameter int CODE_BYTES = 4,
    parameter int WIDE_BEATS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 page_start,
    input  logic [SEL_W-1:0]     size_sel,
    input  logic                 wide_bus,
    input  logic                 read_check,
    input  logic                 din_valid,
    output phase_t               phase,
    output logic [ADDR_W-1:0]    word_addr,
    output logic [$clog2(CODE_BYTES)-1:0] beat,
    output logic                 cfg_wide,
    output logic                 take_data,
    output logic                 take_code,
    output logic                 final_code,
    output logic                 done
);
    localparam int BEAT_W = $clog2(CODE_BYTES);

    logic [SEL_W-1:0]  cfg_sel;
    logic              cfg_read;
    logic [31:0]       words;
    logic [ADDR_W-1:0] last_word;
    logic [BEAT_W-1:0] last_beat;

    // Derive the last word address and the last code beat from the configuration.
    always_comb begin
        words     = (cfg_wide ? 32'(BASE_BYTES / 2) : 32'(BASE_BYTES)) << cfg_sel;
        last_word = ADDR_W'(words - 32'd1);
        last_beat = cfg_wide ? BEAT_W'(WIDE_BEATS - 1) : BEAT_W'(CODE_BYTES - 1);
    end

    // Qualify the beats this phase accepts.
    always_comb begin
        take_data  = din_valid && !page_start && (phase == PH_DATA);
        take_code  = din_valid && !page_start && (phase == PH_CODE);
        final_code = take_code && (beat == last_beat);
    end

    // Advance the phase and counters; page_start restarts the pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_IDLE;
            word_addr <= '0;
            beat      <= '0;
            cfg_sel   <= '0;
            cfg_wide  <= 1'b0;
            cfg_read  <= 1'b0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (page_start) begin
                phase     <= PH_DATA;
                word_addr <= '0;
                beat      <= '0;
                cfg_sel   <= size_sel;
                cfg_wide  <= wide_bus;
                cfg_read  <= read_check;
            end else if (take_data) begin
                if (word_addr == last_word) begin
                    word_addr <= '0;
                    if (cfg_read) begin
                        phase <= PH_CODE;
                    end else begin
                        phase <= PH_HOLD;
                        done  <= 1'b1;
                    end
                end else begin
                    word_addr <= word_addr + 1'b1;
                end
            end else if (take_code) begin
                if (final_code) begin
                    phase <= PH_HOLD;
                    done  <= 1'b1;
                end else begin
                    beat <= beat + 1'b1;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R11
    AST_ADDR_IN_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DATA) |-> (word_addr <= last_word));                  // R3
    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (phase == PH_DATA) && !done);                       // R12
    AST_HOLD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) && !page_start |=> (phase == PH_HOLD) && !done); // R11

endmodule

// File: rtl/ecc_syndrome_class.sv
// Compares the recomputed code with the stored code and classifies the result.
// Clean, single data bit (syndromes complementary), single code bit
// (syndromes differ in one bit) or multiple errors (anything else).
// Assumes the complemented code is parity XOR the replicated bit parity.
module ecc_syndrome_class import ecc_pkg::*; #(
    parameter int POS_W = 16
) (
    input  logic [POS_W-1:0] calc_p,
    input  logic             calc_par,
    input  logic [POS_W-1:0] stored_p,
    input  logic [POS_W-1:0] stored_np,
    output logic [POS_W-1:0] syn_p,
    output logic [POS_W-1:0] syn_np,
    output verdict_t         verdict
);
    logic [POS_W-1:0] calc_np;
    logic [POS_W-1:0] diff;
    logic             clean;
    logic             data_single;
    logic             code_single;

    // Form both syndromes.
    always_comb begin
        calc_np = calc_p ^ {POS_W{calc_par}};
        syn_p   = calc_p ^ stored_p;
        syn_np  = calc_np ^ stored_np;
        diff    = syn_p ^ syn_np;
    end

    // Classify from the syndrome relation.
    always_comb begin
        clean       = (syn_p == '0) && (syn_np == '0);
        data_single = &diff;
        code_single = (diff != '0) && ((diff & (diff - 1'b1)) == '0);
        verdict.err      = !clean;
        verdict.code_err = code_single;
        verdict.mult     = !clean && !data_single && !code_single;
    end

endmodule

// File: rtl/page_ecc_engine.sv
// Page-wide Hamming ECC engine.
// Accumulates one position-XOR code over a whole page of 8- or 16-bit words.
// A write pass leaves the code on the parity outputs. A read pass takes the
// stored code straight after the data and latches a verdict and a syndrome.
// Assumes the stored code beats follow the last data word with no other beat between.
module page_ecc_engine import ecc_pkg::*; #(
    parameter int DATA_W     = 16,
    parameter int ADDR_W     = 12,
    parameter int BIT_W      = 4,
    parameter int SEL_W      = 2,
    parameter int BASE_BYTES = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    page_start,
    input  logic [SEL_W-1:0]        size_sel,
    input  logic                    wide_bus,
    input  logic                    read_check,
    input  logic                    din_valid,
    input  logic [DATA_W-1:0]       din,
    output logic [ADDR_W+BIT_W-1:0] parity_word,
    output logic [ADDR_W+BIT_W-1:0] nparity_word,
    output logic                    err_flag,
    output logic                    mult_flag,
    output logic                    code_flag,
    output logic                    done
);
    localparam int POS_W      = ADDR_W + BIT_W;
    localparam int CODE_W     = 2 * POS_W;
    localparam int BYTE_W     = 8;
    localparam int CODE_BYTES = CODE_W / BYTE_W;
    localparam int WIDE_BEATS = CODE_W / DATA_W;
    localparam int BEAT_W     = $clog2(CODE_BYTES);

    phase_t            phase;
    logic [ADDR_W-1:0] word_addr;
    logic [BEAT_W-1:0] beat;
    logic              cfg_wide;
    logic              take_data;
    logic              take_code;
    logic              final_code;

    logic [POS_W-1:0]  fold_p;
    logic              fold_par;
    logic [POS_W-1:0]  acc_p;
    logic              acc_par;
    logic [CODE_W-1:0] code_r;
    logic [CODE_W-1:0] code_next;

    logic [POS_W-1:0]  syn_p;
    logic [POS_W-1:0]  syn_np;
    verdict_t          verdict;
    logic [POS_W-1:0]  syn_p_r;
    logic [POS_W-1:0]  syn_np_r;
    verdict_t          verdict_r;
    logic              syn_valid;

    ecc_seq_ctrl #(
        .ADDR_W     (ADDR_W),
        .SEL_W      (SEL_W),
        .BASE_BYTES (BASE_BYTES),
        .CODE_BYTES (CODE_BYTES),
        .WIDE_BEATS (WIDE_BEATS)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .page_start (page_start),
        .size_sel   (size_sel),
        .wide_bus   (wide_bus),
        .read_check (read_check),
        .din_valid  (din_valid),
        .phase      (phase),
        .word_addr  (word_addr),
        .beat       (beat),
        .cfg_wide   (cfg_wide),
        .take_data  (take_data),
        .take_code  (take_code),
        .final_code (final_code),
        .done       (done)
    );

    ecc_word_fold #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .BIT_W  (BIT_W)
    ) u_fold (
        .word_addr (word_addr),
        .din       (din),
        .wide      (cfg_wide),
        .pos_xor   (fold_p),
        .bit_par   (fold_par)
    );

    // Merge the current beat into the stored-code image: byte lanes or word lanes.
    always_comb begin
        code_next = code_r;
        if (cfg_wide) begin
            if (int'(beat) < WIDE_BEATS) begin
                code_next[int'(beat) * DATA_W +: DATA_W] = din;
            end
        end else begin
            code_next[int'(beat) * BYTE_W +: BYTE_W] = din[BYTE_W-1:0];
        end
    end

    ecc_syndrome_class #(
        .POS_W (POS_W)
    ) u_class (
        .calc_p    (acc_p),
        .calc_par  (acc_par),
        .stored_p  (code_next[POS_W-1:0]),
        .stored_np (code_next[CODE_W-1:POS_W]),
        .syn_p     (syn_p),
        .syn_np    (syn_np),
        .verdict   (verdict)
    );

    // Accumulate data positions and parity; clear on reset or page start.
    always_ff @(posedge clk) begin
        if (!rst_n || page_start) begin
            acc_p   <= '0;
            acc_par <= 1'b0;
        end else if (take_data) begin
            acc_p   <= acc_p ^ fold_p;
            acc_par <= acc_par ^ fold_par;
        end
    end

    // Collect stored code beats and latch the verdict on the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n || page_start) begin
            code_r    <= '0;
            syn_p_r   <= '0;
            syn_np_r  <= '0;
            verdict_r <= '0;
            syn_valid <= 1'b0;
        end else if (take_code) begin
            code_r <= code_next;
            if (final_code) begin
                syn_p_r   <= syn_p;
                syn_np_r  <= syn_np;
                verdict_r <= verdict;
                syn_valid <= 1'b1;
            end
        end
    end

    // Present the syndrome after a read check, else the running code.
    always_comb begin
        if (syn_valid) begin
            parity_word  = syn_p_r;
            nparity_word = syn_np_r;
        end else begin
            parity_word  = acc_p;
            nparity_word = acc_p ^ {POS_W{acc_par}};
        end
        err_flag  = verdict_r.err;
        mult_flag = verdict_r.mult;
        code_flag = verdict_r.code_err;
    end

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        page_start |=> (parity_word == '0) && (nparity_word == '0) && !err_flag); // R1
    AST_MULT_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        mult_flag |-> err_flag);                                                   // R9
    AST_CODE_NOT_MULT: assert property (@(posedge clk) disable iff (!rst_n)
        code_flag |-> err_flag && !mult_flag);                                     // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD) && !page_start |=> $stable(parity_word) && $stable(err_flag)); // R11
    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) && !page_start |=> $stable(parity_word) && !done);     // R12
    AST_SINGLE_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        done && err_flag && !mult_flag && !code_flag |-> (nparity_word == ~parity_word)); // R7

endmodule

// File: tb/tb_page_ecc_engine.sv
module tb_page_ecc_engine;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        page_start;
    logic [1:0]  size_sel;
    logic        wide_bus;
    logic        read_check;
    logic        din_valid;
    logic [15:0] din;
    logic [15:0] parity_word;
    logic [15:0] nparity_word;
    logic        err_flag;
    logic        mult_flag;
    logic        code_flag;
    logic        done;

    always #2 clk = ~clk;   // 250 MHz

    page_ecc_engine dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .page_start   (page_start),
        .size_sel     (size_sel),
        .wide_bus     (wide_bus),
        .read_check   (read_check),
        .din_valid    (din_valid),
        .din          (din),
        .parity_word  (parity_word),
        .nparity_word (nparity_word),
        .err_flag     (err_flag),
        .mult_flag    (mult_flag),
        .code_flag    (code_flag),
        .done         (done)
    );

    typedef struct {
        string       tag;
        logic [2:0]  flags;   // {err, mult, code}
        logic [15:0] p;
        logic [15:0] np;
        bit          chk_p;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Page content pattern; seed < 0 gives an erased page.
    function automatic logic [7:0] byte_of(input int idx, input int seed);
        if (seed < 0) return 8'hFF;
        return 8'((idx * 37 + seed * 11 + (idx >> 3)) ^ (idx >> 5) ^ (seed << 2));
    endfunction

    function automatic logic [15:0] word_of(input int w, input int seed, input bit wide,
                                            input int fw1, input int fb1,
                                            input int fw2, input int fb2);
        logic [15:0] d;
        d = wide ? {byte_of(2 * w + 1, seed), byte_of(2 * w, seed)} : {8'h00, byte_of(w, seed)};
        if (w == fw1) d[fb1] = ~d[fb1];
        if (w == fw2) d[fb2] = ~d[fb2];
        return d;
    endfunction

    function automatic int words_of(input int sel, input bit wide);
        return wide ? (256 << sel) : (512 << sel);
    endfunction

    // Reference code by the R2 definition.
    function automatic logic [31:0] ref_code(input int sel, input bit wide, input int seed);
        logic [15:0] p;
        logic        par;
        logic [15:0] d;
        p   = '0;
        par = 1'b0;
        for (int w = 0; w < words_of(sel, wide); w++) begin
            d = word_of(w, seed, wide, -1, 0, -1, 0);
            for (int b = 0; b < (wide ? 16 : 8); b++) begin
                if (d[b]) begin
                    p   = p ^ {12'(w), 4'(b)};
                    par = ~par;
                end
            end
        end
        return {p ^ {16{par}}, p};
    endfunction

    task automatic put(input logic [15:0] v);
        @(negedge clk);
        din_valid = 1'b1;
        din       = v;
    endtask

    task automatic idle_bus();
        @(negedge clk);
        din_valid = 1'b0;
        din       = 16'h0;
    endtask

    task automatic start_page(input int sel, input bit wide, input bit rd);
        @(negedge clk);
        page_start = 1'b1;
        size_sel   = 2'(sel);
        wide_bus   = wide;
        read_check = rd;
        din_valid  = 1'b0;
        @(negedge clk);
        page_start = 1'b0;
    endtask

    // Driver: push the expected result and stream one page; narrow words carry junk upper bytes (R4).
    task automatic write_pass(input string tag, input int sel, input bit wide, input int seed,
                              output logic [31:0] code);
        exp_t e;
        code    = ref_code(sel, wide, seed);
        e.tag   = tag;
        e.flags = 3'b000;
        e.p     = code[15:0];
        e.np    = code[31:16];
        e.chk_p = 1'b1;
        exp_q.push_back(e);
        start_page(sel, wide, 1'b0);
        for (int w = 0; w < words_of(sel, wide); w++) begin
            if (wide) put(word_of(w, seed, wide, -1, 0, -1, 0));
            else      put({8'hA5 ^ 8'(w), word_of(w, seed, wide, -1, 0, -1, 0)[7:0]});
        end
        idle_bus();
    endtask

    task automatic read_pass(input exp_t e, input int sel, input bit wide, input int seed,
                             input int fw1, input int fb1, input int fw2, input int fb2,
                             input logic [31:0] code);
        exp_q.push_back(e);
        start_page(sel, wide, 1'b1);
        for (int w = 0; w < words_of(sel, wide); w++) begin
            put(word_of(w, seed, wide, fw1, fb1, fw2, fb2));
        end
        if (wide) begin
            put(code[15:0]);
            put(code[31:16]);
        end else begin
            put({8'h00, code[7:0]});
            put({8'h00, code[15:8]});
            put({8'h00, code[23:16]});
            put({8'h00, code[31:24]});
        end
        idle_bus();
    endtask

    // Monitor: pop the scoreboard on every done pulse and compare.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && done === 1'b1) begin
            if (exp_q.size() == 0) begin
                chk("R11", "unexpected done", 32'(done), 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(e.tag, "flags{err,mult,code}", {29'd0, err_flag, mult_flag, code_flag},
                    {29'd0, e.flags});
                if (e.chk_p) begin
                    chk(e.tag, "parity_word", {16'd0, parity_word}, {16'd0, e.p});
                    chk(e.tag, "nparity_word", {16'd0, nparity_word}, {16'd0, e.np});
                end
            end
        end
    end

    function automatic exp_t mk(input string tag, input logic [2:0] f,
                                input logic [15:0] p, input logic [15:0] np, input bit c);
        exp_t e;
        e.tag = tag; e.flags = f; e.p = p; e.np = np; e.chk_p = c;
        return e;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] c0, c1, c2, cw;
        logic [15:0] keep_p;
        rst_n = 1'b0; page_start = 1'b0; size_sel = 2'd0; wide_bus = 1'b0;
        read_check = 1'b0; din_valid = 1'b0; din = 16'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset outputs", {parity_word, nparity_word}, 32'h0);
        chk("R1", "reset flags/done", {28'd0, err_flag, mult_flag, code_flag, done}, 32'h0);

        // R12 words before the first page_start are ignored
        for (int i = 0; i < 6; i++) put(16'h00FF);
        idle_bus();
        @(negedge clk);
        chk("R12", "idle parity", {parity_word, nparity_word}, 32'h0);

        // R2 / R3 / R4 write passes over all sizes and both widths
        write_pass("R2", 0, 1'b0, 3, c0);
        start_page(0, 1'b0, 1'b0);
        chk("R1", "page_start clears", {parity_word, nparity_word}, 32'h0);
        write_pass("R3", 1, 1'b0, 5, c1);
        write_pass("R3", 2, 1'b0, 6, c2);
        write_pass("R3", 3, 1'b0, 7, c2);
        write_pass("R4", 0, 1'b1, 8, cw);
        write_pass("R4", 1, 1'b1, 9, cw);

        // R12 page_start collides with the final data word
        c0 = ref_code(0, 1'b0, 3);
        start_page(0, 1'b0, 1'b0);
        for (int w = 0; w < 511; w++) put(word_of(w, 3, 1'b0, -1, 0, -1, 0));
        @(negedge clk);
        din_valid = 1'b1; din = word_of(511, 3, 1'b0, -1, 0, -1, 0);
        page_start = 1'b1; size_sel = 2'd0; wide_bus = 1'b0; read_check = 1'b0;
        @(negedge clk);
        page_start = 1'b0; din_valid = 1'b0;
        chk("R12", "done after collision", {31'd0, done}, 32'd0);
        chk("R12", "cleared after collision", {parity_word, nparity_word}, 32'h0);
        exp_q.push_back(mk("R12", 3'b000, c0[15:0], c0[31:16], 1'b1));
        for (int w = 0; w < 512; w++) put(word_of(w, 3, 1'b0, -1, 0, -1, 0));
        idle_bus();

        // R5 / R6 clean read passes, both code beat orders
        read_pass(mk("R6", 3'b000, 16'h0, 16'h0, 1'b1), 0, 1'b0, 3, -1, 0, -1, 0, c0);
        cw = ref_code(1, 1'b1, 9);
        read_pass(mk("R5", 3'b000, 16'h0, 16'h0, 1'b1), 1, 1'b1, 9, -1, 0, -1, 0, cw);

        // R7 single data bit errors
        read_pass(mk("R7", 3'b100, 16'h0000, 16'hFFFF, 1'b1), 0, 1'b0, 3, 0, 0, -1, 0, c0);
        read_pass(mk("R7", 3'b100, {12'd511, 4'd7}, ~{12'd511, 4'd7}, 1'b1),
                  0, 1'b0, 3, 511, 7, -1, 0, c0);
        read_pass(mk("R7", 3'b100, {12'd300, 4'd15}, ~{12'd300, 4'd15}, 1'b1),
                  1, 1'b1, 9, 300, 15, -1, 0, cw);
        c1 = ref_code(3, 1'b0, 7);
        read_pass(mk("R7", 3'b100, {12'd4095, 4'd2}, ~{12'd4095, 4'd2}, 1'b1),
                  3, 1'b0, 7, 4095, 2, -1, 0, c1);

        // R8 single bit error inside the stored code
        read_pass(mk("R8", 3'b101, 16'h0, 16'h0, 1'b0), 0, 1'b0, 3, -1, 0, -1, 0, c0 ^ 32'h0000_0020);
        read_pass(mk("R8", 3'b101, 16'h0, 16'h0, 1'b0), 1, 1'b1, 9, -1, 0, -1, 0, cw ^ 32'h4000_0000);

        // R9 double data bit errors
        read_pass(mk("R9", 3'b110, 16'h0, 16'h0, 1'b0), 0, 1'b0, 3, 10, 1, 200, 6, c0);
        read_pass(mk("R9", 3'b110, 16'h0, 16'h0, 1'b0), 1, 1'b1, 9, 5, 3, 5, 12, cw);

        // R10 erased pages
        read_pass(mk("R10", 3'b110, 16'hFFFF, 16'hFFFF, 1'b1), 0, 1'b0, -1, -1, 0, -1, 0, 32'hFFFF_FFFF);
        read_pass(mk("R10", 3'b110, 16'hFFFF, 16'hFFFF, 1'b1), 2, 1'b1, -1, -1, 0, -1, 0, 32'hFFFF_FFFF);

        // R11 beats after completion are ignored, verdict holds
        keep_p = parity_word;
        for (int i = 0; i < 4; i++) put(16'h1234);
        idle_bus();
        @(negedge clk);
        chk("R11", "parity held", {16'd0, parity_word}, {16'd0, keep_p});
        chk("R11", "flags held", {29'd0, err_flag, mult_flag, code_flag}, 32'd6);

        repeat (4) @(negedge clk);
        chk("R11", "pending expectations", 32'(exp_q.size()), 32'd0);
        summary();
    end

endmodule